// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block works next to a small 32-bit in-order processor core. In each cycle it looks at four event sources: a memory-translation fault, a hardware exception such as a misaligned data access, a hardware break and an external interrupt. It picks at most one of them and computes every architectural change that entering that event causes. These changes are the new program counter, the return address and the register-file slot that receives it, the updated machine status word, and the exception cause, fault address and branch-target capture registers. It also gives the order to clear the per-instruction state flags and to drop any load-reserved reservation.

The core presents the current PC, its instruction-state flags, the current status word and the fault details. One cycle later the block answers with a single-cycle `take` strobe, and all of its results are valid in that cycle. The register file, the translation lookup and the decoder stay in the core. The core applies the results when it sees the strobe.

Top module: `exc_entry_ctrl`

## Requirements
- R1: At most one event is taken per cycle, with the fixed priority translation fault, then hardware exception, then break, then interrupt. `take` pulses in the cycle after the request, and `take_kind` holds 0 for a translation fault, 1 for a hardware exception, 2 for a break and 3 for an interrupt. After reset `take` is low, and no request means no take.
- R2: `new_pc` is `base_vec` plus 0x20 for a translation fault or a hardware exception, plus 0x18 for a break, and plus 0x10 for an interrupt.
- R3: The return register is 14 for an interrupt, 16 for a break and 17 for both exception kinds. The return value is PC for an interrupt or a break, and PC+4 for a hardware exception.
- R4: For a translation fault the return value is PC-8 when the delay-slot and branch-with-immediate flags are both set, and PC-4 when only the delay-slot flag is set. It is PC-4 when only the immediate-prefix flag is set, and PC otherwise.
- R5: An interrupt is taken only when it is requested, status bit 0 (interrupt enable) is set, status bits 2 (break in progress) and 4 (exception in progress) are clear, and neither the delay-slot flag nor the immediate-prefix flag is set.
- R6: The new status word is the current one with bit 0 cleared for an interrupt, bit 2 set for a break, or bit 4 set for either exception kind.
- R7: On every take, status bit 8 (user mode) is copied to bit 9 and status bit 10 (virtual mode) is copied to bit 11, and then bits 8 and 10 are cleared.
- R8: On either exception kind, bit 12 of the cause word equals the delay-slot flag. `btr_we` is raised, with `btr_out` set to the branch target, exactly when that flag is set. Interrupts and breaks write no cause, address or branch-target register.
- R9: A translation fault writes cause bits [4:0] as 16 plus 2 for a miss (`mmu_miss`=1) plus 1 for an instruction fetch. Bit 10 is set for a store. `acc_kind` encodes 00 as load, 01 as store and 10 as fetch. `ear_out` is the fault address.
- R10: A hardware exception writes cause code 1 in bits [4:0]. When `ess_valid` is set, `ess_bits` is placed in bits [11:5]; otherwise those bits are 0. `ear_out` is the fault address.
- R11: A hardware exception request while `cfg_exc_en` is low is ignored. Alone it produces no take, and it never blocks a lower-priority event.
- R12: `iflags_clr` and `resv_clr` are high together exactly in a take cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_vec | input | 32 | Vector base address |
| cur_pc | input | 32 | PC of the current instruction |
| br_target | input | 32 | Pending branch target |
| fault_addr | input | 32 | Faulting data or fetch address |
| in_dslot | input | 1 | Instruction sits in a delay slot |
| in_imm | input | 1 | Instruction follows an immediate prefix |
| in_bimm | input | 1 | Delay-slot branch carried an immediate prefix |
| msr_in | input | 32 | Current machine status word |
| cfg_exc_en | input | 1 | Hardware exceptions configured |
| hwexc_req | input | 1 | Misaligned-data exception request |
| ess_valid | input | 1 | Instruction-specific status bits are valid |
| ess_bits | input | 7 | Instruction-specific status bits |
| mmu_req | input | 1 | Translation fault request |
| mmu_miss | input | 1 | 1 = miss, 0 = protection fault |
| acc_kind | input | 2 | Access type: 00 load, 01 store, 10 fetch |
| brk_req | input | 1 | Hardware break request |
| irq_req | input | 1 | External interrupt request |
| take | output | 1 | Event taken this cycle |
| take_kind | output | 2 | Kind of event taken |
| new_pc | output | 32 | Vector address |
| rf_idx | output | 5 | Register receiving the return address |
| rf_data | output | 32 | Return address |
| msr_out | output | 32 | Updated status word |
| esr_we | output | 1 | Cause word write enable |
| esr_out | output | 32 | Cause word |
| ear_we | output | 1 | Fault address write enable |
| ear_out | output | 32 | Fault address |
| btr_we | output | 1 | Branch-target capture enable |
| btr_out | output | 32 | Captured branch target |
| iflags_clr | output | 1 | Clear instruction-state flags |
| resv_clr | output | 1 | Drop load-reserved reservation |

## Verification
The hardest case to reach is an interrupt that is requested while every gate but one is open. One test blocks it in turn with interrupt enable, break in progress, exception in progress, the delay-slot flag and the immediate-prefix flag. Another set of tests stacks the interrupt behind higher-priority events, so that a wrong gate or a wrong priority order shows up as a spurious or missing take. The return-address rewind needs the rarer flag mixes on a translation fault: delay slot with and without branch-immediate, and immediate prefix alone. These are driven directly, and a long stretch of random flag, status and request patterns follows, compared with the model on every clock.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int RIDX_W    = 5;
  localparam int ESS_W     = 7;
  localparam int CAUSE_W   = 5;

  typedef enum logic [1:0] {
    EV_MMU = 2'd0,
    EV_HWE = 2'd1,
    EV_BRK = 2'd2,
    EV_IRQ = 2'd3
  } ev_kind_e;

  // status word bit positions; each saved mode bit sits one above its live bit
  localparam int ST_IE  = 0;
  localparam int ST_BIP = 2;
  localparam int ST_EIP = 4;
  localparam int ST_UM  = 8;
  localparam int ST_VM  = 10;
  localparam int N_MODE = 2;

  // cause word layout
  localparam int CW_ESS_LSB = 5;
  localparam int CW_STORE   = 10;
  localparam int CW_DS      = 12;
  localparam logic [CAUSE_W-1:0] CODE_MISALIGN = 5'd1;
  localparam logic [CAUSE_W-1:0] CODE_XLAT     = 5'd16;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [RIDX_W-1:0] RX_IRQ = 5'd14;
  localparam logic [RIDX_W-1:0] RX_BRK = 5'd16;
  localparam logic [RIDX_W-1:0] RX_EXC = 5'd17;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
  import exc_pkg::*;
(
  input  logic     mmu_req,
  input  logic     hwexc_req,
  input  logic     cfg_exc_en,
  input  logic     brk_req,
  input  logic     irq_req,
  input  logic     st_ie,
  input  logic     st_bip,
  input  logic     st_eip,
  input  logic     in_dslot,
  input  logic     in_imm,
  output logic     take,
  output ev_kind_e kind
);
  logic irq_open;
  logic hwe_live;

  always_comb begin
    irq_open = irq_req & st_ie & ~st_bip & ~st_eip & ~in_dslot & ~in_imm;
    hwe_live = hwexc_req & cfg_exc_en;
    take     = 1'b1;
    kind     = EV_MMU;
    if (mmu_req)       kind = EV_MMU;
    else if (hwe_live) kind = EV_HWE;
    else if (brk_req)  kind = EV_BRK;
    else if (irq_open) kind = EV_IRQ;
    else               take = 1'b0;
  end
endmodule

// File: rtl/exc_ret_calc.sv
`timescale 1ns/1ps
module exc_ret_calc
  import exc_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int OFS_IRQ = 'h10,
  parameter int OFS_BRK = 'h18,
  parameter int OFS_EXC = 'h20
)(
  input  ev_kind_e          kind,
  input  logic [W-1:0]      base_vec,
  input  logic [W-1:0]      cur_pc,
  input  logic              in_dslot,
  input  logic              in_imm,
  input  logic              in_bimm,
  output logic [W-1:0]      vec_pc,
  output logic [RIDX_W-1:0] ret_idx,
  output logic [W-1:0]      ret_val
);
  localparam logic [W-1:0] STEP  = W'(4);
  localparam logic [W-1:0] STEP2 = W'(8);

  logic [W-1:0] xlat_ret;

  always_comb begin
    if (in_dslot)    xlat_ret = in_bimm ? cur_pc - STEP2 : cur_pc - STEP;
    else if (in_imm) xlat_ret = cur_pc - STEP;
    else             xlat_ret = cur_pc;

    unique case (kind)
      EV_MMU: begin
        vec_pc  = base_vec + W'(OFS_EXC);
        ret_idx = RX_EXC;
        ret_val = xlat_ret;
      end
      EV_HWE: begin
        vec_pc  = base_vec + W'(OFS_EXC);
        ret_idx = RX_EXC;
        ret_val = cur_pc + STEP;
      end
      EV_BRK: begin
        vec_pc  = base_vec + W'(OFS_BRK);
        ret_idx = RX_BRK;
        ret_val = cur_pc;
      end
      default: begin
        vec_pc  = base_vec + W'(OFS_IRQ);
        ret_idx = RX_IRQ;
        ret_val = cur_pc;
      end
    endcase
  end
endmodule

// File: rtl/exc_status_calc.sv
`timescale 1ns/1ps
module exc_status_calc
  import exc_pkg::*;
#(
  parameter int W = XLEN
)(
  input  ev_kind_e         kind,
  input  logic [W-1:0]     msr_in,
  input  logic             in_dslot,
  input  logic             ess_valid,
  input  logic [ESS_W-1:0] ess_bits,
  input  logic             mmu_miss,
  input  logic [1:0]       acc_kind,
  output logic [W-1:0]     msr_nxt,
  output logic [W-1:0]     cause_nxt,
  output logic             exc_wr,
  output logic             btr_wr
);
  localparam int MODE_POS [N_MODE] = '{ST_UM, ST_VM};

  always_comb begin
    msr_nxt = msr_in;
    unique case (kind)
      EV_IRQ:  msr_nxt[ST_IE]  = 1'b0;
      EV_BRK:  msr_nxt[ST_BIP] = 1'b1;
      default: msr_nxt[ST_EIP] = 1'b1;
    endcase
    for (int i = 0; i < N_MODE; i++) begin
      msr_nxt[MODE_POS[i]+1] = msr_in[MODE_POS[i]];
      msr_nxt[MODE_POS[i]]   = 1'b0;
    end
  end

  always_comb begin
    cause_nxt         = '0;
    cause_nxt[CW_DS]  = in_dslot;
    exc_wr            = 1'b0;
    if (kind == EV_MMU) begin
      exc_wr                  = 1'b1;
      cause_nxt[CAUSE_W-1:0]  = CODE_XLAT | {3'b000, mmu_miss, (acc_kind == ACC_FETCH)};
      cause_nxt[CW_STORE]     = (acc_kind == ACC_STORE);
    end else if (kind == EV_HWE) begin
      exc_wr                  = 1'b1;
      cause_nxt[CAUSE_W-1:0]  = CODE_MISALIGN;
      if (ess_valid) cause_nxt[CW_ESS_LSB +: ESS_W] = ess_bits;
    end
    btr_wr = exc_wr & in_dslot;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int OFS_IRQ = 'h10,
  parameter int OFS_BRK = 'h18,
  parameter int OFS_EXC = 'h20
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      base_vec,
  input  logic [W-1:0]      cur_pc,
  input  logic [W-1:0]      br_target,
  input  logic [W-1:0]      fault_addr,
  input  logic              in_dslot,
  input  logic              in_imm,
  input  logic              in_bimm,
  input  logic [W-1:0]      msr_in,
  input  logic              cfg_exc_en,
  input  logic              hwexc_req,
  input  logic              ess_valid,
  input  logic [ESS_W-1:0]  ess_bits,
  input  logic              mmu_req,
  input  logic              mmu_miss,
  input  logic [1:0]        acc_kind,
  input  logic              brk_req,
  input  logic              irq_req,
  output logic              take,
  output logic [1:0]        take_kind,
  output logic [W-1:0]      new_pc,
  output logic [RIDX_W-1:0] rf_idx,
  output logic [W-1:0]      rf_data,
  output logic [W-1:0]      msr_out,
  output logic              esr_we,
  output logic [W-1:0]      esr_out,
  output logic              ear_we,
  output logic [W-1:0]      ear_out,
  output logic              btr_we,
  output logic [W-1:0]      btr_out,
  output logic              iflags_clr,
  output logic              resv_clr
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // next-state logic
  logic              take_d;
  ev_kind_e          kind_d;
  logic [W-1:0]      vec_d, ret_d, msr_d, cause_d;
  logic [RIDX_W-1:0] idx_d;
  logic              exc_wr_d, btr_wr_d;

  exc_arbiter u_arb (
    .mmu_req    (mmu_req),
    .hwexc_req  (hwexc_req),
    .cfg_exc_en (cfg_exc_en),
    .brk_req    (brk_req),
    .irq_req    (irq_req),
    .st_ie      (msr_in[ST_IE]),
    .st_bip     (msr_in[ST_BIP]),
    .st_eip     (msr_in[ST_EIP]),
    .in_dslot   (in_dslot),
    .in_imm     (in_imm),
    .take       (take_d),
    .kind       (kind_d)
  );

  exc_ret_calc #(.W(W), .OFS_IRQ(OFS_IRQ), .OFS_BRK(OFS_BRK), .OFS_EXC(OFS_EXC)) u_ret (
    .kind     (kind_d),
    .base_vec (base_vec),
    .cur_pc   (cur_pc),
    .in_dslot (in_dslot),
    .in_imm   (in_imm),
    .in_bimm  (in_bimm),
    .vec_pc   (vec_d),
    .ret_idx  (idx_d),
    .ret_val  (ret_d)
  );

  exc_status_calc #(.W(W)) u_st (
    .kind      (kind_d),
    .msr_in    (msr_in),
    .in_dslot  (in_dslot),
    .ess_valid (ess_valid),
    .ess_bits  (ess_bits),
    .mmu_miss  (mmu_miss),
    .acc_kind  (acc_kind),
    .msr_nxt   (msr_d),
    .cause_nxt (cause_d),
    .exc_wr    (exc_wr_d),
    .btr_wr    (btr_wr_d)
  );

  // registers; payload loads only on a take
  logic              take_q;
  ev_kind_e          kind_q;
  logic [W-1:0]      vec_q, ret_q, msr_q, cause_q, ear_q, btr_q;
  logic [RIDX_W-1:0] idx_q;
  logic              exc_wr_q, btr_wr_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      take_q   <= 1'b0;
      kind_q   <= EV_MMU;
      vec_q    <= '0;
      ret_q    <= '0;
      msr_q    <= '0;
      cause_q  <= '0;
      ear_q    <= '0;
      btr_q    <= '0;
      idx_q    <= '0;
      exc_wr_q <= 1'b0;
      btr_wr_q <= 1'b0;
    end else begin
      take_q <= take_d;
      if (take_d) begin
        kind_q   <= kind_d;
        vec_q    <= vec_d;
        ret_q    <= ret_d;
        msr_q    <= msr_d;
        cause_q  <= cause_d;
        ear_q    <= fault_addr;
        btr_q    <= br_target;
        idx_q    <= idx_d;
        exc_wr_q <= exc_wr_d;
        btr_wr_q <= btr_wr_d;
      end
    end
  end

  assign take       = take_q;
  assign take_kind  = kind_q;
  assign new_pc     = vec_q;
  assign rf_idx     = idx_q;
  assign rf_data    = ret_q;
  assign msr_out    = msr_q;
  assign esr_we     = take_q & exc_wr_q;
  assign esr_out    = cause_q;
  assign ear_we     = take_q & exc_wr_q;
  assign ear_out    = ear_q;
  assign btr_we     = take_q & btr_wr_q;
  assign btr_out    = btr_q;
  assign iflags_clr = take_q;
  assign resv_clr   = take_q;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int W = XLEN
)(
  input logic         clk,
  input logic         rst_sync_n,
  input logic         take,
  input logic [1:0]   take_kind,
  input logic [W-1:0] msr_in,
  input logic [W-1:0] msr_out,
  input logic         mmu_req,
  input logic         hwexc_req,
  input logic         cfg_exc_en,
  input logic         brk_req,
  input logic         irq_req,
  input logic         in_dslot,
  input logic         in_imm,
  input logic         esr_we,
  input logic [W-1:0] esr_out,
  input logic         btr_we
);
  AST_XLAT_FIRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(mmu_req) |-> (take && take_kind == EV_MMU)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(mmu_req || hwexc_req || brk_req || irq_req) |-> !take); // R1

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && take_kind == EV_IRQ) |->
      ($past(msr_in[ST_IE]) && !$past(msr_in[ST_BIP]) && !$past(msr_in[ST_EIP])
       && !$past(in_dslot) && !$past(in_imm))); // R5

  AST_IRQ_IE_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && take_kind == EV_IRQ) |-> !msr_out[ST_IE]); // R6

  AST_MODE_SAVED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |-> (msr_out[ST_UM+1] == $past(msr_in[ST_UM]) && msr_out[ST_VM+1] == $past(msr_in[ST_VM])
              && !msr_out[ST_UM] && !msr_out[ST_VM])); // R7

  AST_DS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    esr_we |-> (esr_out[CW_DS] == $past(in_dslot) && btr_we == $past(in_dslot))); // R8

  AST_HWE_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && take_kind == EV_HWE) |-> $past(cfg_exc_en)); // R11
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .take       (take),
  .take_kind  (take_kind),
  .msr_in     (msr_in),
  .msr_out    (msr_out),
  .mmu_req    (mmu_req),
  .hwexc_req  (hwexc_req),
  .cfg_exc_en (cfg_exc_en),
  .brk_req    (brk_req),
  .irq_req    (irq_req),
  .in_dslot   (in_dslot),
  .in_imm     (in_imm),
  .esr_we     (esr_we),
  .esr_out    (esr_out),
  .btr_we     (btr_we)
);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] base_vec, cur_pc, br_target, fault_addr, msr_in;
  logic        in_dslot, in_imm, in_bimm, cfg_exc_en, hwexc_req, ess_valid;
  logic [6:0]  ess_bits;
  logic        mmu_req, mmu_miss, brk_req, irq_req;
  logic [1:0]  acc_kind;
  logic        take, esr_we, ear_we, btr_we, iflags_clr, resv_clr;
  logic [1:0]  take_kind;
  logic [31:0] new_pc, rf_data, msr_out, esr_out, ear_out, btr_out;
  logic [4:0]  rf_idx;

  always #4 clk = ~clk; // 125 MHz

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .base_vec(base_vec), .cur_pc(cur_pc),
    .br_target(br_target), .fault_addr(fault_addr), .in_dslot(in_dslot),
    .in_imm(in_imm), .in_bimm(in_bimm), .msr_in(msr_in), .cfg_exc_en(cfg_exc_en),
    .hwexc_req(hwexc_req), .ess_valid(ess_valid), .ess_bits(ess_bits),
    .mmu_req(mmu_req), .mmu_miss(mmu_miss), .acc_kind(acc_kind),
    .brk_req(brk_req), .irq_req(irq_req), .take(take), .take_kind(take_kind),
    .new_pc(new_pc), .rf_idx(rf_idx), .rf_data(rf_data), .msr_out(msr_out),
    .esr_we(esr_we), .esr_out(esr_out), .ear_we(ear_we), .ear_out(ear_out),
    .btr_we(btr_we), .btr_out(btr_out), .iflags_clr(iflags_clr), .resv_clr(resv_clr)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // expected values, computed from the requirements
  bit          x_take, x_exc, x_btr;
  int          x_kind, x_idx;
  logic [31:0] x_pc, x_ret, x_msr, x_esr, x_ear, x_btr_v;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model();
    bit irq_ok;
    irq_ok = irq_req && msr_in[0] && !msr_in[2] && !msr_in[4] && !in_dslot && !in_imm;
    x_take = 1;
    if (mmu_req)                       x_kind = 0;
    else if (hwexc_req && cfg_exc_en)  x_kind = 1;
    else if (brk_req)                  x_kind = 2;
    else if (irq_ok)                   x_kind = 3;
    else begin x_take = 0; x_kind = 0; end
    case (x_kind)
      0: begin x_pc = base_vec + 32'h20; x_idx = 17;
               x_ret = in_dslot ? (in_bimm ? cur_pc - 8 : cur_pc - 4) : (in_imm ? cur_pc - 4 : cur_pc); end
      1: begin x_pc = base_vec + 32'h20; x_idx = 17; x_ret = cur_pc + 4; end
      2: begin x_pc = base_vec + 32'h18; x_idx = 16; x_ret = cur_pc; end
      default: begin x_pc = base_vec + 32'h10; x_idx = 14; x_ret = cur_pc; end
    endcase
    x_msr = msr_in;
    if (x_kind == 3) x_msr[0] = 0; else if (x_kind == 2) x_msr[2] = 1; else x_msr[4] = 1;
    x_msr[9] = msr_in[8]; x_msr[11] = msr_in[10]; x_msr[8] = 0; x_msr[10] = 0;
    x_exc = (x_kind <= 1);
    x_esr = 0;
    x_esr[12] = in_dslot;
    if (x_kind == 0) begin
      x_esr[4:0] = 5'd16 + (mmu_miss ? 5'd2 : 5'd0) + (acc_kind == 2'b10 ? 5'd1 : 5'd0);
      x_esr[10]  = (acc_kind == 2'b01);
    end else begin
      x_esr[4:0] = 5'd1;
      if (ess_valid) x_esr[11:5] = ess_bits;
    end
    x_ear   = fault_addr;
    x_btr   = x_exc && in_dslot;
    x_btr_v = br_target;
  endtask

  task automatic compare();
    chk("R1/R5/R11 take", {31'b0, take}, {31'b0, x_take});
    chk("R12 flush", {30'b0, iflags_clr, resv_clr}, x_take ? 32'd3 : 32'd0);
    if (x_take) begin
      chk("R1 kind", {30'b0, take_kind}, x_kind);
      chk("R2 vector", new_pc, x_pc);
      chk("R3 return index", {27'b0, rf_idx}, x_idx);
      chk(x_kind == 0 ? "R4 return value" : "R3 return value", rf_data, x_ret);
      chk("R6 status word", msr_out, x_msr);
      chk("R7 mode bits", msr_out & 32'hF00, x_msr & 32'hF00);
      chk("R8 cause write", {30'b0, esr_we, ear_we}, x_exc ? 32'd3 : 32'd0);
      chk("R8 branch capture", {31'b0, btr_we}, {31'b0, x_btr});
      if (x_btr) chk("R8 branch target", btr_out, x_btr_v);
      if (x_exc) begin
        chk(x_kind == 0 ? "R9 cause" : "R10 cause", esr_out, x_esr);
        chk(x_kind == 0 ? "R9 address" : "R10 address", ear_out, x_ear);
      end
    end
  endtask

  task automatic clr_reqs();
    mmu_req = 0; hwexc_req = 0; brk_req = 0; irq_req = 0;
  endtask

  task automatic clr_all();
    clr_reqs();
    in_dslot = 0; in_imm = 0; in_bimm = 0; ess_valid = 0; ess_bits = 0;
    mmu_miss = 0; acc_kind = 0; cfg_exc_en = 1; msr_in = 32'h1;
  endtask

  task automatic cycle();
    model();
    @(posedge clk);
    @(negedge clk);
    compare();
    clr_reqs();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    base_vec = 32'hF000_0000; cur_pc = 32'h0000_1000; br_target = 32'h0000_4444;
    fault_addr = 32'hDEAD_BEE1;
    clr_all();
    repeat (3) @(negedge clk);
    chk("R1 reset take", {31'b0, take}, 32'd0);
    chk("R12 reset flush", {30'b0, iflags_clr, resv_clr}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {31'b0, take}, 32'd0);

    cycle(); // idle
    // R10: misaligned access in a delay slot with specific bits; R8 capture
    hwexc_req = 1; ess_valid = 1; ess_bits = 7'h2A; in_dslot = 1; cycle();
    clr_all(); hwexc_req = 1; ess_bits = 7'h7F; cycle();
    // R11: exceptions not configured
    clr_all(); cfg_exc_en = 0; hwexc_req = 1; cycle();
    clr_all(); cfg_exc_en = 0; hwexc_req = 1; brk_req = 1; cycle();
    // R9: all translation fault codes and access kinds
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 3; a++) begin
        clr_all(); mmu_req = 1; mmu_miss = m[0]; acc_kind = a[1:0];
        fault_addr = 32'h1000_0000 + a; cycle();
      end
    // R4: return rewind
    clr_all(); mmu_req = 1; in_dslot = 1; in_bimm = 1; cycle();
    clr_all(); mmu_req = 1; in_dslot = 1; cycle();
    clr_all(); mmu_req = 1; in_imm = 1; cycle();
    clr_all(); mmu_req = 1; cycle();
    // R5: interrupt accepted, then blocked by each gate
    clr_all(); irq_req = 1; cycle();
    clr_all(); irq_req = 1; msr_in = 32'h0; cycle();
    clr_all(); irq_req = 1; msr_in = 32'h5; cycle();
    clr_all(); irq_req = 1; msr_in = 32'h11; cycle();
    clr_all(); irq_req = 1; in_dslot = 1; cycle();
    clr_all(); irq_req = 1; in_imm = 1; cycle();
    // R3/R6: break
    clr_all(); brk_req = 1; msr_in = 32'h0; cycle();
    // R1: priority
    clr_all(); mmu_req = 1; hwexc_req = 1; brk_req = 1; irq_req = 1; cycle();
    clr_all(); hwexc_req = 1; brk_req = 1; irq_req = 1; cycle();
    clr_all(); brk_req = 1; irq_req = 1; cycle();
    // R7: mode save with all mode bits set
    clr_all(); msr_in = 32'hFFFF_FFEB; brk_req = 1; cycle();
    clr_all(); msr_in = 32'h0000_0501; irq_req = 1; cycle();
    clr_all(); msr_in = 32'h0000_0A00; mmu_req = 1; cycle();
    // random mix, compared on every clock
    for (int i = 0; i < 600; i++) begin
      cur_pc = $urandom; br_target = $urandom; fault_addr = $urandom;
      base_vec = $urandom & 32'hFFFF_FF00; msr_in = $urandom;
      if ($urandom_range(0, 1) == 1) msr_in[4:0] = 5'b00001;
      in_dslot = ($urandom_range(0, 3) == 0); in_imm = ($urandom_range(0, 3) == 0);
      in_bimm = in_dslot && ($urandom_range(0, 1) == 1);
      cfg_exc_en = ($urandom_range(0, 3) != 0); ess_valid = $urandom_range(0, 1) == 1;
      ess_bits = 7'($urandom); mmu_miss = $urandom_range(0, 1) == 1;
      acc_kind = 2'($urandom_range(0, 2));
      mmu_req = ($urandom_range(0, 5) == 0); hwexc_req = ($urandom_range(0, 4) == 0);
      brk_req = ($urandom_range(0, 4) == 0); irq_req = ($urandom_range(0, 1) == 1);
      cycle();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule